// File: doc/BRIEF.md
# Supervisory Power Mode Sequencer

This block sequences the operating modes of a supervisory companion chip that owns the reset line of a host microcontroller. It tracks seven modes: Init, Normal, Stop, Sleep, Software Flash, Restart and Fail-safe. Mode changes come from decoded serial-port commands, watchdog fault pulses, a supply undervoltage flag, wake events and thermal events. From the current mode it drives the active-low reset output, the active-low limp-home output, a watchdog-configuration freeze, a LIN slope-control enable and the CAN/LIN transceiver enables.

Software Flash mode is for reprogramming the controller. Entering it from Normal pulses the reset line. It can only be left through Restart, so leaving it also resets the controller. Restart holds reset low for a programmable delay and then returns to Normal by itself. Restart stores a 3-bit cause code, which software reads and clears with a status-read strobe. A limp-home output that is already active stays active through Restart.

All event inputs are single-cycle pulses that are sampled on the rising clock edge. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset: `mode_out` is Init (0), `rst_out_n`=1, `limp_out_n`=1, `restart_cause`=0, both transceiver enables are 0, `lin_slope_en`=1 and `wd_cfg_freeze`=0. Mode codes are: 0 Init, 1 Normal, 2 Stop, 3 Sleep, 4 Flash, 5 Restart, 6 Fail-safe. A command is valid when `cmd_valid`=1, and `cmd_mode` then carries the code of the target mode.
- R2: In Init:
  - a Normal command moves the block to Normal;
  - a watchdog timeout moves it to Restart with cause 6;
  - an undervoltage moves it to Restart with cause 4.
- R3: A Flash command in Normal enters Flash mode. On entry, `rst_out_n` goes low for exactly FLASH_RST_CYC cycles. Throughout Flash mode: `wd_cfg_freeze`=1, `lin_slope_en`=0, and `can_en`=`lin_en`=1.
- R4: Flash mode ignores Normal, Stop, Sleep and Flash commands. Its only exits are Restart and Fail-safe.
- R5: Cause codes are: 1 SPI restart command, 2 watchdog timeout, 3 watchdog window fail, 4 undervoltage.
  - In Normal, Stop and Flash, an undervoltage, a watchdog timeout or a window fail enters Restart.
  - A Restart command enters Restart only from Normal and Flash.
  - When several causes occur in the same cycle, the stored cause follows the priority undervoltage > timeout > window fail > command.
- R6: Restart lasts SHORT_DLY cycles when `dly_long`=0, or LONG_DLY cycles when it is 1. The value is sampled on the entry cycle. `rst_out_n` stays low throughout Restart. The block then enters Normal with `rst_out_n`=1.
- R7: The cause code is loaded on every entry into Restart. It holds, including after the return to Normal, until a `stat_rd` pulse clears it to 0. If a load and a read fall in the same cycle, the load wins.
- R8: Wake events:
  - In Sleep, a wake moves the block to Restart with cause 5 and sets `wake_seen`, but raises no `irq_pulse`.
  - In Stop, a wake gives a one-cycle `irq_pulse`, sets `wake_seen`, and the block stays in Stop.
  - `stat_rd` clears `wake_seen`.
- R9: `therm_sd` moves the block from any mode to Fail-safe, overriding every other event. `rst_out_n` is low in Fail-safe. A wake or a cool-down event then moves the block to Restart with cause 7.
- R10: `limp_set` drives `limp_out_n` low in Normal or Flash. Entering or leaving Restart does not release it. `limp_clr` releases it only in Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded mode command strobe |
| cmd_mode | input | 3 | Target mode code of the command |
| wd_timeout | input | 1 | Watchdog timeout pulse |
| wd_win_fail | input | 1 | Watchdog window failure pulse |
| vcc_uv | input | 1 | Controller supply undervoltage flag |
| wake_evt | input | 1 | Wake event pulse |
| cool_evt | input | 1 | Thermal cool-down event pulse |
| therm_sd | input | 1 | Thermal shutdown event |
| dly_long | input | 1 | Restart delay select (1 = long) |
| limp_set | input | 1 | Command to activate limp-home |
| limp_clr | input | 1 | Command to release limp-home |
| stat_rd | input | 1 | Status read strobe, clears cause and wake flag |
| rst_out_n | output | 1 | Active-low controller reset |
| limp_out_n | output | 1 | Active-low limp-home output |
| wd_cfg_freeze | output | 1 | Watchdog configuration locked |
| lin_slope_en | output | 1 | LIN slope control enable |
| can_en | output | 1 | CAN transceiver enable |
| lin_en | output | 1 | LIN transceiver enable |
| irq_pulse | output | 1 | One-cycle interrupt on wake in Stop |
| wake_seen | output | 1 | Wake recorded since last status read |
| restart_cause | output | 3 | Latched restart cause code |
| mode_out | output | 3 | Current mode code |

## Verification
The bench builds the block with SHORT_DLY=6, LONG_DLY=13 and FLASH_RST_CYC=3. These small values let the bench count every cycle of reset low in both delay settings and in the flash entry pulse. Because each Restart is short, the bench can sweep all fifteen combinations of simultaneous restart causes in each of Normal, Stop and Flash. It also drives the thermal shutdown from every mode and checks each exit from Fail-safe.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    MD_INIT     = 3'd0,
    MD_NORMAL   = 3'd1,
    MD_STOP     = 3'd2,
    MD_SLEEP    = 3'd3,
    MD_FLASH    = 3'd4,
    MD_RESTART  = 3'd5,
    MD_FAILSAFE = 3'd6
  } mode_e;

  typedef enum logic [2:0] {
    CS_NONE  = 3'd0,
    CS_SPI   = 3'd1,
    CS_WDTO  = 3'd2,
    CS_WDWIN = 3'd3,
    CS_UV    = 3'd4,
    CS_WAKE  = 3'd5,
    CS_INIT  = 3'd6,
    CS_FSREC = 3'd7
  } cause_e;
endpackage

// File: rtl/pmc_countdown.sv
module pmc_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_q <= '0;
    else if (load)           count_q <= load_val;
    else if (count_q != '0)  count_q <= count_q - 1'b1;
  end
endmodule

// File: rtl/pmc_cause_latch.sv
module pmc_cause_latch
  import pmc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  cause_e cause_in,
  input  logic   clear,
  output cause_e cause_q
);
  // A new cause wins over a simultaneous read so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cause_q <= CS_NONE;
    else if (load)  cause_q <= cause_in;
    else if (clear) cause_q <= CS_NONE;
  end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_mode,
  input  logic       wd_timeout,
  input  logic       wd_win_fail,
  input  logic       vcc_uv,
  input  logic       wake_evt,
  input  logic       cool_evt,
  input  logic       therm_sd,
  input  logic       dly_done,
  output mode_e      mode_q,
  output logic       go_restart,
  output cause_e     cause_new,
  output logic       flash_entry
);
  mode_e  nxt;
  cause_e flt;

  function automatic logic cmd_is(input logic v, input logic [2:0] c, input mode_e m);
    return v && (c == m);
  endfunction

  always_comb begin
    if (vcc_uv)           flt = CS_UV;
    else if (wd_timeout)  flt = CS_WDTO;
    else if (wd_win_fail) flt = CS_WDWIN;
    else                  flt = CS_NONE;
  end

  always_comb begin
    nxt         = mode_q;
    go_restart  = 1'b0;
    cause_new   = CS_NONE;
    flash_entry = 1'b0;
    unique case (mode_q)
      MD_INIT: begin
        if (vcc_uv) begin
          go_restart = 1'b1; cause_new = CS_UV;
        end else if (wd_timeout) begin
          go_restart = 1'b1; cause_new = CS_INIT;
        end else if (cmd_is(cmd_valid, cmd_mode, MD_NORMAL)) nxt = MD_NORMAL;
      end
      MD_NORMAL: begin
        if (flt != CS_NONE) begin
          go_restart = 1'b1; cause_new = flt;
        end else if (cmd_is(cmd_valid, cmd_mode, MD_RESTART)) begin
          go_restart = 1'b1; cause_new = CS_SPI;
        end else if (cmd_is(cmd_valid, cmd_mode, MD_STOP))  nxt = MD_STOP;
        else if (cmd_is(cmd_valid, cmd_mode, MD_SLEEP))     nxt = MD_SLEEP;
        else if (cmd_is(cmd_valid, cmd_mode, MD_FLASH)) begin
          nxt = MD_FLASH; flash_entry = 1'b1;
        end
      end
      MD_STOP: begin
        if (flt != CS_NONE) begin
          go_restart = 1'b1; cause_new = flt;
        end else if (cmd_is(cmd_valid, cmd_mode, MD_NORMAL)) nxt = MD_NORMAL;
      end
      MD_FLASH: begin
        if (flt != CS_NONE) begin
          go_restart = 1'b1; cause_new = flt;
        end else if (cmd_is(cmd_valid, cmd_mode, MD_RESTART)) begin
          go_restart = 1'b1; cause_new = CS_SPI;
        end
      end
      MD_SLEEP: begin
        if (wake_evt) begin
          go_restart = 1'b1; cause_new = CS_WAKE;
        end
      end
      MD_RESTART: begin
        if (dly_done) nxt = MD_NORMAL;
      end
      MD_FAILSAFE: begin
        if (wake_evt || cool_evt) begin
          go_restart = 1'b1; cause_new = CS_FSREC;
        end
      end
      default: nxt = MD_INIT;
    endcase
    if (go_restart) nxt = MD_RESTART;
    // Thermal shutdown overrides every other event
    if (therm_sd && mode_q != MD_FAILSAFE) begin
      nxt         = MD_FAILSAFE;
      go_restart  = 1'b0;
      flash_entry = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_INIT;
    else        mode_q <= nxt;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SHORT_DLY     = 2048,
  parameter int LONG_DLY      = 16384,
  parameter int FLASH_RST_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_mode,
  input  logic       wd_timeout,
  input  logic       wd_win_fail,
  input  logic       vcc_uv,
  input  logic       wake_evt,
  input  logic       cool_evt,
  input  logic       therm_sd,
  input  logic       dly_long,
  input  logic       limp_set,
  input  logic       limp_clr,
  input  logic       stat_rd,
  output logic       rst_out_n,
  output logic       limp_out_n,
  output logic       wd_cfg_freeze,
  output logic       lin_slope_en,
  output logic       can_en,
  output logic       lin_en,
  output logic       irq_pulse,
  output logic       wake_seen,
  output logic [2:0] restart_cause,
  output logic [2:0] mode_out
);
  localparam int MAXD = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int CW   = $clog2(MAXD + 1);
  localparam int PW   = $clog2(FLASH_RST_CYC + 1);

  mode_e          mode_q;
  logic           go_restart, flash_entry;
  cause_e         cause_new, cause_q;
  logic [CW-1:0]  dly_cnt;
  logic [PW-1:0]  pls_cnt;
  logic           limp_q, irq_q, wake_q;

  pmc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .wd_timeout(wd_timeout), .wd_win_fail(wd_win_fail),
    .vcc_uv(vcc_uv), .wake_evt(wake_evt), .cool_evt(cool_evt),
    .therm_sd(therm_sd), .dly_done(dly_cnt == CW'(1)),
    .mode_q(mode_q), .go_restart(go_restart),
    .cause_new(cause_new), .flash_entry(flash_entry)
  );

  pmc_countdown #(.W(CW)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(go_restart),
    .load_val(dly_long ? CW'(LONG_DLY) : CW'(SHORT_DLY)),
    .count_q(dly_cnt)
  );

  pmc_countdown #(.W(PW)) u_pls (
    .clk(clk), .rst_n(rst_n), .load(flash_entry),
    .load_val(PW'(FLASH_RST_CYC)), .count_q(pls_cnt)
  );

  pmc_cause_latch u_cause (
    .clk(clk), .rst_n(rst_n), .load(go_restart), .cause_in(cause_new),
    .clear(stat_rd), .cause_q(cause_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limp_q <= 1'b0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (limp_set && (mode_q == MD_NORMAL || mode_q == MD_FLASH)) limp_q <= 1'b1;
      else if (limp_clr && mode_q == MD_NORMAL)                    limp_q <= 1'b0;
      irq_q <= wake_evt && (mode_q == MD_STOP);
      if (wake_evt && (mode_q == MD_STOP || mode_q == MD_SLEEP)) wake_q <= 1'b1;
      else if (stat_rd)                                          wake_q <= 1'b0;
    end
  end

  assign rst_out_n     = !(mode_q == MD_RESTART || mode_q == MD_FAILSAFE || pls_cnt != '0);
  assign limp_out_n    = !limp_q;
  assign wd_cfg_freeze = (mode_q == MD_FLASH);
  assign lin_slope_en  = (mode_q != MD_FLASH);
  assign can_en        = (mode_q == MD_NORMAL || mode_q == MD_FLASH);
  assign lin_en        = can_en;
  assign irq_pulse     = irq_q;
  assign wake_seen     = wake_q;
  assign restart_cause = cause_q;
  assign mode_out      = mode_q;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       rst_out_n,
  input logic       limp_out_n,
  input logic       wd_cfg_freeze,
  input logic       lin_slope_en,
  input logic       can_en,
  input logic       irq_pulse,
  input logic [2:0] restart_cause
);
  assert_flash_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_FLASH) |-> (wd_cfg_freeze && !lin_slope_en && can_en));

  assert_flash_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_FLASH) |=> (mode == MD_FLASH || mode == MD_RESTART || mode == MD_FAILSAFE));

  assert_reset_in_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RESTART) |-> !rst_out_n);

  assert_restart_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RESTART) |=> (mode == MD_RESTART || mode == MD_NORMAL || mode == MD_FAILSAFE));

  assert_cause_on_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RESTART && $past(mode) != MD_RESTART) |-> (restart_cause != 3'd0));

  assert_no_irq_from_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SLEEP) |=> !irq_pulse);

  assert_reset_in_failsafe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_FAILSAFE) |-> !rst_out_n);

  assert_limp_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!limp_out_n && mode != MD_NORMAL) |=> !limp_out_n);
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_out), .rst_out_n(rst_out_n),
  .limp_out_n(limp_out_n), .wd_cfg_freeze(wd_cfg_freeze),
  .lin_slope_en(lin_slope_en), .can_en(can_en), .irq_pulse(irq_pulse),
  .restart_cause(restart_cause)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  localparam int SD = 6, LD = 13, FP = 3;
  localparam int M_INIT = 0, M_NORM = 1, M_STOP = 2, M_SLEEP = 3,
                 M_FLASH = 4, M_RST = 5, M_FS = 6;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0; logic [2:0] cmd_mode = 0;
  logic wd_timeout = 0, wd_win_fail = 0, vcc_uv = 0, wake_evt = 0, cool_evt = 0;
  logic therm_sd = 0, dly_long = 0, limp_set = 0, limp_clr = 0, stat_rd = 0;
  logic rst_out_n, limp_out_n, wd_cfg_freeze, lin_slope_en, can_en, lin_en;
  logic irq_pulse, wake_seen;
  logic [2:0] restart_cause, mode_out;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.SHORT_DLY(SD), .LONG_DLY(LD), .FLASH_RST_CYC(FP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .wd_timeout(wd_timeout), .wd_win_fail(wd_win_fail), .vcc_uv(vcc_uv),
    .wake_evt(wake_evt), .cool_evt(cool_evt), .therm_sd(therm_sd),
    .dly_long(dly_long), .limp_set(limp_set), .limp_clr(limp_clr),
    .stat_rd(stat_rd), .rst_out_n(rst_out_n), .limp_out_n(limp_out_n),
    .wd_cfg_freeze(wd_cfg_freeze), .lin_slope_en(lin_slope_en),
    .can_en(can_en), .lin_en(lin_en), .irq_pulse(irq_pulse),
    .wake_seen(wake_seen), .restart_cause(restart_cause), .mode_out(mode_out));

  task automatic chk(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clr_in();
    cmd_valid = 0; wd_timeout = 0; wd_win_fail = 0; vcc_uv = 0; wake_evt = 0;
    cool_evt = 0; therm_sd = 0; limp_set = 0; limp_clr = 0; stat_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); clr_in(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cmd(input int m);
    cmd_valid = 1; cmd_mode = m[2:0];
    @(negedge clk); clr_in();
  endtask

  task automatic goto_mode(input int m);
    do_reset();
    if (m == M_INIT) return;
    cmd(M_NORM);
    if (m == M_STOP || m == M_SLEEP || m == M_RST) cmd(m);
    if (m == M_FLASH) begin
      cmd(M_FLASH);
      repeat (FP) @(negedge clk);
    end
  endtask

  // Count cycles spent in Restart from the current sample on, reset low throughout
  task automatic wait_restart(input string req, input int exp_len);
    int n = 0;
    int low_ok = 1;
    while (mode_out == M_RST && n < 100) begin
      if (rst_out_n) low_ok = 0;
      n++;
      @(negedge clk);
    end
    chk({req, " restart length"}, n, exp_len);
    chk({req, " reset low in restart"}, low_ok, 1);
    chk({req, " back to normal"}, mode_out, M_NORM);
    chk({req, " reset released"}, rst_out_n, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 mode", mode_out, M_INIT);
    chk("R1 rst_out_n", rst_out_n, 1);
    chk("R1 limp", limp_out_n, 1);
    chk("R1 cause", restart_cause, 0);
    chk("R1 can_en", can_en, 0);
    chk("R1 lin_en", lin_en, 0);
    chk("R1 slope", lin_slope_en, 1);
    chk("R1 freeze", wd_cfg_freeze, 0);

    // R2 Init exits
    cmd(M_NORM);
    chk("R2 init to normal", mode_out, M_NORM);
    do_reset();
    wd_timeout = 1; @(negedge clk); clr_in();
    chk("R2 init timeout mode", mode_out, M_RST);
    chk("R2 init timeout cause", restart_cause, 6);
    wait_restart("R6 short", SD);
    do_reset();
    vcc_uv = 1; @(negedge clk); clr_in();
    chk("R2 init uv cause", restart_cause, 4);

    // R6 delay select, both settings
    for (int dl = 0; dl < 2; dl++) begin
      goto_mode(M_NORM);
      dly_long = dl[0];
      cmd(M_RST);
      dly_long = ~dl[0];
      wait_restart("R6 delay select", dl ? LD : SD);
      dly_long = 0;
    end

    // R5 priority sweep in Normal, Stop, Flash
    for (int mi = 0; mi < 3; mi++) begin
      for (int mask = 1; mask < 16; mask++) begin
        int md, exp_c, exp_m;
        md = (mi == 0) ? M_NORM : (mi == 1) ? M_STOP : M_FLASH;
        goto_mode(md);
        vcc_uv = mask[3]; wd_timeout = mask[2]; wd_win_fail = mask[1];
        if (mask[0]) begin cmd_valid = 1; cmd_mode = 3'(M_RST); end
        @(negedge clk); clr_in();
        exp_c = mask[3] ? 4 : mask[2] ? 2 : mask[1] ? 3 : (md != M_STOP) ? 1 : 0;
        exp_m = (exp_c == 0) ? md : M_RST;
        chk("R5 mode", mode_out, exp_m);
        chk("R5 cause", restart_cause, exp_c);
      end
    end

    // R3 flash entry pulse and outputs
    goto_mode(M_NORM);
    cmd(M_FLASH);
    begin
      int lows = 0;
      for (int k = 0; k < FP + 3; k++) begin
        if (!rst_out_n) lows++;
        if (k == 0) begin
          chk("R3 mode flash", mode_out, M_FLASH);
          chk("R3 freeze", wd_cfg_freeze, 1);
          chk("R3 slope off", lin_slope_en, 0);
          chk("R3 can_en", can_en, 1);
          chk("R3 lin_en", lin_en, 1);
        end
        @(negedge clk);
      end
      chk("R3 entry reset cycles", lows, FP);
    end
    // R4 non-restart commands ignored in Flash
    for (int c = 1; c <= 4; c++) begin
      cmd(c);
      chk("R4 stays in flash", mode_out, M_FLASH);
      chk("R4 reset stays high", rst_out_n, 1);
    end
    cmd(M_RST);
    chk("R4 flash exits to restart", mode_out, M_RST);
    chk("R4 cause spi", restart_cause, 1);
    wait_restart("R4 flash restart", SD);

    // R7 cause held until read, load wins over read
    repeat (4) @(negedge clk);
    chk("R7 cause held", restart_cause, 1);
    stat_rd = 1; @(negedge clk); clr_in();
    chk("R7 cleared by read", restart_cause, 0);
    vcc_uv = 1; stat_rd = 1; @(negedge clk); clr_in();
    chk("R7 load beats read", restart_cause, 4);

    // R8 wake in Sleep and Stop
    goto_mode(M_SLEEP);
    chk("R8 sleep can off", can_en, 0);
    wake_evt = 1; @(negedge clk); clr_in();
    chk("R8 sleep wake mode", mode_out, M_RST);
    chk("R8 sleep wake cause", restart_cause, 5);
    chk("R8 sleep wake flag", wake_seen, 1);
    chk("R8 sleep no irq", irq_pulse, 0);
    goto_mode(M_STOP);
    wake_evt = 1; @(negedge clk); clr_in();
    chk("R8 stop irq", irq_pulse, 1);
    chk("R8 stop stays", mode_out, M_STOP);
    chk("R8 stop wake flag", wake_seen, 1);
    @(negedge clk);
    chk("R8 irq one cycle", irq_pulse, 0);
    stat_rd = 1; @(negedge clk); clr_in();
    chk("R8 flag cleared", wake_seen, 0);

    // R9 thermal shutdown from every mode, both exits
    for (int m = 0; m <= 5; m++) begin
      goto_mode(m);
      therm_sd = 1; wake_evt = (m == M_SLEEP); @(negedge clk); clr_in();
      chk("R9 to failsafe", mode_out, M_FS);
      chk("R9 reset low", rst_out_n, 0);
      if (m[0]) cool_evt = 1; else wake_evt = 1;
      @(negedge clk); clr_in();
      chk("R9 exit to restart", mode_out, M_RST);
      chk("R9 cause", restart_cause, 7);
    end

    // R10 limp-home survives restart, release only in Normal
    goto_mode(M_STOP);
    limp_set = 1; @(negedge clk); clr_in();
    chk("R10 set ignored in stop", limp_out_n, 1);
    cmd(M_NORM);
    limp_set = 1; @(negedge clk); clr_in();
    chk("R10 set in normal", limp_out_n, 0);
    cmd(M_FLASH);
    repeat (FP) @(negedge clk);
    limp_clr = 1; @(negedge clk); clr_in();
    chk("R10 clr ignored in flash", limp_out_n, 0);
    vcc_uv = 1; @(negedge clk); clr_in();
    chk("R10 kept entering restart", limp_out_n, 0);
    wait_restart("R10 restart", SD);
    chk("R10 kept after restart", limp_out_n, 0);
    limp_clr = 1; @(negedge clk); clr_in();
    chk("R10 clr in normal", limp_out_n, 1);
    goto_mode(M_FLASH);
    limp_set = 1; @(negedge clk); clr_in();
    chk("R10 set in flash", limp_out_n, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule